// File: doc/BRIEF.md
# Programmable Tick Timer

A tick timer for a processor core, reached through two 32-bit registers: a mode register and a count register. Software picks the register with a one-bit select and reads or writes it through a plain port. The count register advances once for each pulse on a tick-enable input, and that input is meant to pulse at a 20 MHz rate. The mode register holds a compare period, an interrupt enable, a sticky interrupt-pending flag and a two-bit mode field.

A match happens on a tick when the low period-width bits of the counter equal the period. On a match, the block can latch a pending interrupt and drive a level interrupt line. It then clears the counter, stops it, or lets it run on, according to the mode. When the mode is disabled, the counter stays frozen. A one-shot stop ends at the next write to the mode register.

Top module: `tick_timer`

## Requirements
- R1: After reset both registers read as zero and irq_o is low.
- R2: sel_i=0 selects the mode register and sel_i=1 selects the count register. The mode register fields are: period in bits [27:0], pending in bit 28, interrupt enable in bit 29 and mode in bits [31:30]. A written value reads back unchanged.
- R3: When the mode is non-zero and the counter is not stopped, each cycle with tick_i high adds one to the counter. Cycles without tick_i leave the counter unchanged.
- R4: In mode 00 (disabled) the counter does not move on ticks, and no match occurs, so pending stays clear.
- R5: The match compares only counter bits [27:0] with the period. Bits [31:28] of the counter are ignored.
- R6: A match while the enable bit (bit 29) is 1 sets the pending bit (bit 28). A match with the enable bit at 0 leaves pending clear. irq_o is high exactly when both pending and enable are 1.
- R7: The pending bit stays set until software writes 0 to bit 28 of the mode register.
- R8: In mode 01 (restart), a match loads the counter with zero, and counting continues from zero.
- R9: In mode 10 (one-shot), a match stops the counter, which then holds its value on further ticks. Writing a non-zero mode resumes counting from the held value.
- R10: In mode 11 (continuous), the counter keeps incrementing through a match. The next match comes only after bits [27:0] wrap past their maximum and reach the period again.
- R11: A write to the count register takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Register select: 0 mode, 1 count |
| we_i | input | 1 | Write strobe for the selected register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register (combinational) |
| tick_i | input | 1 | Count-enable pulse, one per 20 MHz period |
| irq_o | output | 1 | Level interrupt request |

## Verification
Errors in the counter or the stop flag appear on the count readback in the cycle after the faulty tick. A counter that moves in disabled mode, skips a held value or fails to clear shows up after one tick. A wrong compare width or a wrong wrap point shows up as a pending bit and irq_o that rise one tick early or late, or never. This includes the case where the upper counter bits are set and must be ignored. A pending bit that is not sticky, or that is set while the enable bit is clear, is visible on irq_o and in bit 28 of the mode readback one cycle after the match or the clearing write.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_RESTART = 2'b01,
    MODE_ONESHOT = 2'b10,
    MODE_CONT    = 2'b11
  } tt_mode_e;
endpackage

// File: rtl/tt_mode_reg.sv
module tt_mode_reg
  import tick_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PERIOD_W = 28
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                match_i,
  output logic [PERIOD_W-1:0] period_o,
  output logic                pend_o,
  output logic                ie_o,
  output tt_mode_e            mode_o
);
  localparam int PEND_BIT = PERIOD_W;
  localparam int IE_BIT   = PERIOD_W + 1;
  localparam int MODE_LSB = PERIOD_W + 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o <= '0;
      ie_o     <= 1'b0;
      mode_o   <= MODE_OFF;
    end else if (we_i) begin
      period_o <= wdata_i[PERIOD_W-1:0];
      ie_o     <= wdata_i[IE_BIT];
      mode_o   <= tt_mode_e'(wdata_i[MODE_LSB +: 2]);
    end
  end

  // a match set wins over a clearing write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= 1'b0;
    else         pend_o <= (we_i ? wdata_i[PEND_BIT] : pend_o) | (match_i & ie_o);
  end

  // R7
  pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !we_i |=> pend_o);
  // R6
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i && ie_o |=> pend_o);
endmodule

// File: rtl/tt_ctrl.sv
module tt_ctrl
  import tick_timer_pkg::*;
#(
  parameter int PERIOD_W = 28
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  tt_mode_e            mode_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [PERIOD_W-1:0] cnt_low_i,
  input  logic                mode_we_i,
  output logic                match_o,
  output logic                clear_o,
  output logic                inc_o
);
  logic stopped_q;
  logic run;
  logic halt;

  assign run     = (mode_i != MODE_OFF) && !stopped_q;
  assign match_o = tick_i && run && (cnt_low_i == period_i);
  assign clear_o = match_o && (mode_i == MODE_RESTART);
  assign halt    = match_o && (mode_i inside {MODE_RESTART, MODE_ONESHOT});
  assign inc_o   = tick_i && run && !halt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 stopped_q <= 1'b0;
    else if (mode_we_i)                          stopped_q <= 1'b0;
    else if (match_o && mode_i == MODE_ONESHOT)  stopped_q <= 1'b1;
  end

  // R9
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_q |-> !inc_o && !match_o);
  // R4
  off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_OFF |-> !inc_o && !match_o);
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              clear_i,
  input  logic              inc_i,
  output logic [DATA_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (load_i)  cnt_o <= load_val_i;
    else if (clear_i) cnt_o <= '0;
    else if (inc_i)   cnt_o <= cnt_o + 1'b1;
  end

  // R11
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(load_val_i));
  // R8
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !load_i |=> cnt_o == '0);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PERIOD_W = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  output logic              irq_o
);
  logic [PERIOD_W-1:0] period;
  logic                pend, ie;
  tt_mode_e            mode;
  logic [DATA_W-1:0]   cnt;
  logic                match, clear, inc;
  logic                mode_we, cnt_we;

  assign mode_we = we_i && !sel_i;
  assign cnt_we  = we_i && sel_i;

  tt_mode_reg #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_mode (
    .clk_i, .rst_ni, .we_i(mode_we), .wdata_i, .match_i(match),
    .period_o(period), .pend_o(pend), .ie_o(ie), .mode_o(mode)
  );

  tt_ctrl #(.PERIOD_W(PERIOD_W)) u_ctrl (
    .clk_i, .rst_ni, .tick_i, .mode_i(mode), .period_i(period),
    .cnt_low_i(cnt[PERIOD_W-1:0]), .mode_we_i(mode_we),
    .match_o(match), .clear_o(clear), .inc_o(inc)
  );

  tt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(cnt_we), .load_val_i(wdata_i),
    .clear_i(clear), .inc_i(inc), .cnt_o(cnt)
  );

  assign rdata_o = sel_i ? cnt : {mode, ie, pend, period};
  assign irq_o   = pend && ie;

  // R6
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ie);
  // R4
  disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MODE_OFF && !cnt_we |=> $stable(cnt));
endmodule

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0, tick = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tick_timer u_tick_timer (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .irq_o(irq)
  );

  // op: 0 write, 1 tick n times, 2 check readback, 3 check irq
  localparam int NV = 37;
  localparam logic [38:0] VEC [NV] = '{
    {2'd0, 1'b0, 32'h0000_0005, 4'd2},  // R2 disabled, period 5
    {2'd2, 1'b0, 32'h0000_0005, 4'd2},
    {2'd1, 1'b0, 32'd4,         4'd4},  // R4
    {2'd2, 1'b1, 32'h0000_0000, 4'd4},
    {2'd3, 1'b0, 32'd0,         4'd4},
    {2'd0, 1'b1, 32'h0000_0003, 4'd11}, // R11
    {2'd2, 1'b1, 32'h0000_0003, 4'd11},
    {2'd0, 1'b0, 32'h6000_0005, 4'd8},  // R8 restart, ie, period 5
    {2'd1, 1'b0, 32'd1,         4'd3},  // R3
    {2'd2, 1'b1, 32'h0000_0004, 4'd3},
    {2'd1, 1'b0, 32'd1,         4'd3},
    {2'd2, 1'b1, 32'h0000_0005, 4'd3},
    {2'd1, 1'b0, 32'd1,         4'd8},
    {2'd2, 1'b1, 32'h0000_0000, 4'd8},
    {2'd3, 1'b0, 32'd1,         4'd6},  // R6
    {2'd2, 1'b0, 32'h7000_0005, 4'd6},
    {2'd1, 1'b0, 32'd3,         4'd7},  // R7
    {2'd3, 1'b0, 32'd1,         4'd7},
    {2'd0, 1'b0, 32'h6000_0005, 4'd7},
    {2'd3, 1'b0, 32'd0,         4'd7},
    {2'd0, 1'b0, 32'h4000_0002, 4'd6},  // R6 ie off, period 2
    {2'd0, 1'b1, 32'h0000_0000, 4'd6},
    {2'd1, 1'b0, 32'd3,         4'd8},
    {2'd2, 1'b1, 32'h0000_0000, 4'd8},
    {2'd2, 1'b0, 32'h4000_0002, 4'd6},
    {2'd0, 1'b0, 32'hA000_0002, 4'd9},  // R9 one-shot, ie, period 2
    {2'd1, 1'b0, 32'd3,         4'd9},
    {2'd2, 1'b1, 32'h0000_0002, 4'd9},
    {2'd1, 1'b0, 32'd5,         4'd9},
    {2'd2, 1'b1, 32'h0000_0002, 4'd9},
    {2'd0, 1'b0, 32'hC000_0002, 4'd9},  // resume in continuous, ie off
    {2'd1, 1'b0, 32'd1,         4'd9},
    {2'd2, 1'b1, 32'h0000_0003, 4'd9},
    {2'd0, 1'b0, 32'hE000_0002, 4'd10}, // R10 continuous, ie
    {2'd0, 1'b1, 32'h0FFF_FFFE, 4'd10},
    {2'd1, 1'b0, 32'd2,         4'd10},
    {2'd2, 1'b1, 32'h1000_0000, 4'd10}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic s, input logic [31:0] d);
    sel = s; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic read_chk(input logic s, input logic [31:0] exp, input int req);
    sel = s;
    #1;
    chk(rdata, exp, req);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    read_chk(1'b0, 32'h0, 1);
    read_chk(1'b1, 32'h0, 1);
    chk({31'b0, irq}, 32'h0, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][38:37])
        2'd0: do_write(VEC[v][36], VEC[v][35:4]);
        2'd1: do_ticks(int'(VEC[v][35:4]));
        2'd2: read_chk(VEC[v][36], VEC[v][35:4], int'(VEC[v][3:0]));
        default: begin #1; chk({31'b0, irq}, VEC[v][35:4], int'(VEC[v][3:0])); end
      endcase
    end

    // R10 / R5: upper bits set, low bits must wrap to period before the next match
    chk({31'b0, irq}, 32'h0, 10);
    do_ticks(2);
    read_chk(1'b1, 32'h1000_0002, 10);
    chk({31'b0, irq}, 32'h0, 5);
    do_ticks(1);
    read_chk(1'b1, 32'h1000_0003, 10);
    chk({31'b0, irq}, 32'h1, 5);

    // R3 no tick, no movement
    repeat (4) @(negedge clk);
    read_chk(1'b1, 32'h1000_0003, 3);

    // R11 write and tick in the same cycle
    sel = 1'b1; we = 1'b1; wdata = 32'h0000_0100; tick = 1'b1;
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
    read_chk(1'b1, 32'h0000_0100, 11);

    // R7 write of 1 to pending keeps it; write of 0 clears
    do_write(1'b0, 32'hF000_0002);
    chk({31'b0, irq}, 32'h1, 7);
    do_write(1'b0, 32'hE000_0002);
    chk({31'b0, irq}, 32'h0, 7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule